// File: doc/BRIEF.md
# Searchable Queue with Single-Cycle Clear

This block is a small synchronous first-in first-out queue that adds two operations to the usual ones. Entries go in through an enqueue port guarded by a ready signal. The oldest entry is visible at all times on a head port, and a dequeue port removes it. A clear input empties the whole queue at the next clock edge. A purely combinational search port takes a key and reports whether any entry now held in the queue carries that key in a fixed bit field.

The occupancy is tracked by a three-state machine. `SQ_EMPTY` holds no entries. `SQ_PARTIAL` holds between one and DEPTH-1 entries. `SQ_FULL` holds DEPTH entries. The transitions are:
- *fill-start*: `SQ_EMPTY` to `SQ_PARTIAL` on an accepted enqueue.
- *fill-up*: `SQ_PARTIAL` to `SQ_FULL` on an enqueue with no dequeue at DEPTH-1 entries.
- *drain-out*: `SQ_PARTIAL` to `SQ_EMPTY` on a dequeue with no enqueue at one entry.
- *unfill*: `SQ_FULL` to `SQ_PARTIAL` on an accepted dequeue.
- *flush*: any state to `SQ_EMPTY` when clear is asserted.

A typical use is as a buffer between two pipeline stages. The producer stage searches the buffer for a tag before it issues work that depends on that tag.

Top module: `searchable_queue`

## Requirements
- R1: After reset the queue is empty: `deq_rdy`=0, `enq_rdy`=1 and `find_hit`=0 for any key.
- R2: `enq_rdy` is 0 exactly when DEPTH entries are held. An enqueue is accepted when `enq_en`=1, `enq_rdy`=1 and `clr_en`=0. An `enq_en` while full changes neither the contents nor the head.
- R3: `deq_rdy` is 1 exactly when at least one entry is held. `deq_en` while empty has no effect.
- R4: Entries leave in the order they were accepted. `head_data` shows the oldest held entry whenever `deq_rdy`=1.
- R5: Peeking does not remove anything: with `deq_en`=0 and `clr_en`=0, `head_data` keeps its value and `deq_rdy` stays 1.
- R6: With `clr_en`=1 the queue is empty in the next cycle (`deq_rdy`=0, `enq_rdy`=1).
- R7: Clear wins over enqueue and dequeue asserted in the same cycle. The queue ends empty and the offered data is discarded.
- R8: On a queue that is neither empty nor full, an enqueue and a dequeue in the same cycle both take effect, and the occupancy is unchanged.
- R9: On a full queue, an enqueue and a dequeue in the same cycle give a dequeue only: the offered entry is refused and DEPTH-1 entries remain.
- R10: `find_hit` is 1 in the same cycle exactly when some held entry has bits `[KEY_LSB +: KEY_W]` equal to `find_key`. An empty queue never hits.
- R11: Entries removed by dequeue or clear never cause a hit, even though their storage slots keep the old bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_en | input | 1 | Empty the queue at the next edge |
| enq_en | input | 1 | Request to append `enq_data` |
| enq_data | input | DATA_W | Entry to append |
| enq_rdy | output | 1 | Queue can accept an entry |
| deq_en | input | 1 | Request to remove the head entry |
| deq_rdy | output | 1 | Queue holds an entry; head is valid |
| head_data | output | DATA_W | Oldest held entry |
| find_key | input | KEY_W | Key to search for |
| find_hit | output | 1 | Some held entry carries `find_key` |

## Verification
Clear can coincide with an enqueue, a dequeue or both. The bench drives all three together on a partly filled queue and expects empty status next cycle, with no hit for the key of the discarded entry. Enqueue and dequeue also coincide, both on a full queue and on a partial queue. A behavioural queue model judges every cycle's ready flags, head and search result before the edge. The search is also taken in the same cycle as an enqueue of the searched key. It must miss until the following cycle.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    typedef enum logic [1:0] {
        SQ_EMPTY   = 2'd0,
        SQ_PARTIAL = 2'd1,
        SQ_FULL    = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_en,
    input  logic          deq_en,
    input  logic          clr_en,
    output logic          wr_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          enq_rdy,
    output logic          deq_rdy
);
    sq_state_e     state_q, state_d;
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          push, pop;

    assign push  = enq_en & enq_rdy & ~clr_en;
    assign pop   = deq_en & deq_rdy & ~clr_en;
    assign wr_go = push;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clr_en) begin
            state_d = SQ_EMPTY;                        // flush
        end else begin
            unique case (state_q)
                SQ_EMPTY:   if (push) state_d = SQ_PARTIAL;   // fill-start
                SQ_PARTIAL: begin
                    if (push && !pop && cnt_q == CW'(DEPTH - 1))
                        state_d = SQ_FULL;                     // fill-up
                    else if (pop && !push && cnt_q == CW'(1))
                        state_d = SQ_EMPTY;                    // drain-out
                end
                SQ_FULL:    if (pop) state_d = SQ_PARTIAL;     // unfill
                default:    state_d = SQ_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SQ_EMPTY:   begin enq_rdy = 1'b1; deq_rdy = 1'b0; end
            SQ_PARTIAL: begin enq_rdy = 1'b1; deq_rdy = 1'b1; end
            SQ_FULL:    begin enq_rdy = 1'b0; deq_rdy = 1'b1; end
            default:    begin enq_rdy = 1'b0; deq_rdy = 1'b0; end
        endcase
    end

    // pointer and occupancy datapath
    always_ff @(posedge clk) begin
        if (!rst_n || clr_en) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + AW'(1);
            if (pop)  rd_q <= rd_q + AW'(1);
            if (push && !pop)      cnt_q <= cnt_q + CW'(1);
            else if (pop && !push) cnt_q <= cnt_q - CW'(1);
        end
    end

    assign wr_ptr = wr_q;
    assign rd_ptr = rd_q;
    assign count  = cnt_q;
endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_go,
    input  logic [AW-1:0]                wr_ptr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [AW-1:0]                rd_ptr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [DEPTH-1:0][DATA_W-1:0] slots
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     mem_q <= '0;
        else if (wr_go) mem_q[wr_ptr] <= wr_data;
    end

    assign rd_data = mem_q[rd_ptr];
    assign slots   = mem_q;
endmodule

// File: rtl/sfq_match.sv
module sfq_match #(
    parameter int DATA_W  = 16,
    parameter int KEY_W   = 4,
    parameter int KEY_LSB = 4,
    parameter int DEPTH   = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] slots,
    input  logic [AW-1:0]                rd_ptr,
    input  logic [CW-1:0]                count,
    input  logic [KEY_W-1:0]             key,
    output logic                         hit
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AW-1:0] age;
        logic          live;
        assign age        = AW'(i) - rd_ptr;            // distance from head
        assign live       = {1'b0, age} < count;
        assign hit_vec[i] = live && (slots[i][KEY_LSB +: KEY_W] == key);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/searchable_queue.sv
module searchable_queue #(
    parameter int DATA_W  = 16,
    parameter int KEY_W   = 4,
    parameter int KEY_LSB = 4,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              enq_en,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_rdy,
    input  logic              deq_en,
    output logic              deq_rdy,
    output logic [DATA_W-1:0] head_data,
    input  logic [KEY_W-1:0]  find_key,
    output logic              find_hit
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic                         wr_go;
    logic [AW-1:0]                wr_ptr, rd_ptr;
    logic [CW-1:0]                count;
    logic [DEPTH-1:0][DATA_W-1:0] slots;

    sfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .enq_en(enq_en), .deq_en(deq_en), .clr_en(clr_en),
        .wr_go(wr_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
        .enq_rdy(enq_rdy), .deq_rdy(deq_rdy)
    );

    sfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_go(wr_go), .wr_ptr(wr_ptr), .wr_data(enq_data),
        .rd_ptr(rd_ptr), .rd_data(head_data), .slots(slots)
    );

    sfq_match #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .DEPTH(DEPTH)) u_match (
        .slots(slots), .rd_ptr(rd_ptr), .count(count),
        .key(find_key), .hit(find_hit)
    );
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_en,
    input logic              enq_en,
    input logic [DATA_W-1:0] enq_data,
    input logic              enq_rdy,
    input logic              deq_en,
    input logic              deq_rdy,
    input logic [DATA_W-1:0] head_data,
    input logic              find_hit
);
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_rdy && !deq_en && !clr_en) |=> (!enq_rdy && $stable(head_data)));

    p_first_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!deq_rdy && enq_en && !clr_en) |=> (deq_rdy && head_data == $past(enq_data)));

    p_peek_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_rdy && !deq_en && !clr_en) |=> (deq_rdy && $stable(head_data)));

    p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (!deq_rdy && enq_rdy));

    p_full_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_rdy && enq_en && deq_en && !clr_en) |=> (enq_rdy && deq_rdy));

    p_empty_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_rdy |-> !find_hit);
endmodule

bind searchable_queue sfq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en),
    .enq_en(enq_en), .enq_data(enq_data), .enq_rdy(enq_rdy),
    .deq_en(deq_en), .deq_rdy(deq_rdy), .head_data(head_data),
    .find_hit(find_hit)
);

// File: tb/searchable_queue_test.sv
module searchable_queue_test;
    localparam int DATA_W = 16, KEY_W = 4, KEY_LSB = 4, DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic clr_en = 0, enq_en = 0, deq_en = 0;
    logic [DATA_W-1:0] enq_data = '0;
    logic [KEY_W-1:0]  find_key = '0;
    logic enq_rdy, deq_rdy, find_hit;
    logic [DATA_W-1:0] head_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [DATA_W-1:0] model[$];

    always #10 clk = ~clk;

    searchable_queue #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en),
        .enq_en(enq_en), .enq_data(enq_data), .enq_rdy(enq_rdy),
        .deq_en(deq_en), .deq_rdy(deq_rdy), .head_data(head_data),
        .find_key(find_key), .find_hit(find_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [KEY_W-1:0] k);
        foreach (model[i]) if (model[i][KEY_LSB +: KEY_W] == k) return 1'b1;
        return 1'b0;
    endfunction

    // drive one cycle, compare all outputs before the edge, then advance the model
    task automatic step(input bit e, input logic [DATA_W-1:0] d, input bit dq,
                        input bit c, input logic [KEY_W-1:0] k, input string tag);
        bit push, pop;
        @(negedge clk);
        enq_en = e; enq_data = d; deq_en = dq; clr_en = c; find_key = k;
        #1;
        chk({tag, " R2 enq_rdy"}, 32'(enq_rdy), 32'(model.size() < DEPTH));
        chk({tag, " R3 deq_rdy"}, 32'(deq_rdy), 32'(model.size() > 0));
        if (model.size() > 0) chk({tag, " R4 head"}, 32'(head_data), 32'(model[0]));
        chk({tag, " R10 find"}, 32'(find_hit), 32'(model_hit(k)));
        if (c) model.delete();
        else begin
            push = e && (model.size() < DEPTH);
            pop  = dq && (model.size() > 0);
            if (pop)  void'(model.pop_front());
            if (push) model.push_back(d);
        end
    endtask

    function automatic logic [DATA_W-1:0] mk(input int key, input int tag);
        return {8'(8'hA0 + tag), 4'(key), 4'(tag)};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset deq_rdy", 32'(deq_rdy), 0);
        chk("R1 reset enq_rdy", 32'(enq_rdy), 1);
        chk("R1 reset find", 32'(find_hit), 0);

        step(0, '0, 1, 0, 4'd0, "R3 deq on empty");
        step(0, '0, 0, 0, 4'd0, "R3 after empty deq");
        step(1, mk(1, 1), 0, 0, 4'd1, "R10 search during enq");
        step(1, mk(2, 2), 0, 0, 4'd1, "R10 hit key1");
        step(1, mk(3, 3), 0, 0, 4'd2, "R10 hit key2");
        step(1, mk(4, 4), 0, 0, 4'd7, "R10 miss");
        step(1, mk(9, 5), 0, 0, 4'd4, "R2 enq while full");
        step(0, '0, 0, 0, 4'd9, "R2 refused not found");
        step(0, '0, 0, 0, 4'd3, "R5 peek hold");
        step(1, mk(6, 6), 1, 0, 4'd1, "R9 full enq+deq");
        step(0, '0, 0, 0, 4'd6, "R9 result");
        step(1, mk(7, 7), 1, 0, 4'd1, "R8 mid enq+deq");
        step(0, '0, 0, 0, 4'd7, "R8 result");
        step(0, '0, 1, 0, 4'd3, "R4 drain");
        step(0, '0, 1, 0, 4'd3, "R11 removed key");
        step(0, '0, 1, 0, 4'd4, "R4 drain");
        step(0, '0, 0, 0, 4'd4, "R11 removed key");
        step(1, mk(5, 8), 0, 0, 4'd5, "R4 refill");
        step(1, mk(8, 9), 0, 0, 4'd5, "R10 hit after wrap");
        step(1, mk(2, 10), 1, 1, 4'd2, "R7 clear+enq+deq");
        step(0, '0, 0, 0, 4'd2, "R7 discarded miss");
        step(0, '0, 0, 0, 4'd5, "R11 cleared key");
        step(1, mk(12, 11), 0, 0, 4'd12, "R6 refill");
        step(1, mk(13, 12), 0, 0, 4'd12, "R6 refill");
        step(0, '0, 0, 1, 4'd13, "R6 clear");
        step(0, '0, 0, 0, 4'd13, "R6 after clear");
        step(0, '0, 0, 0, 4'd12, "R11 stale slot");
        for (int i = 0; i < 6; i++)
            step(1, mk(i, 16 + i), (i % 2) == 1, 0, 4'(i), "R8 mixed traffic");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule